// File: doc/BRIEF.md
# Page-Buffered Write Protection Controller

This block sits between the serial command sequencer of a small byte-wide non-volatile memory and its 256×8 cell array. It owns the 8-bit status byte: a busy flag, a write-enable latch and a two-bit block-protect code. It also owns a 16-byte page buffer. The sequencer reports each decoded command on a one-cycle strobe with a 3-bit code. It passes received data bytes one at a time, then signals either a normal termination (`term_i`) or an abort (`abort_i`).

On a normal termination the controller decides whether the pending write may run. If it may, it starts a self-timed write cycle. During the cycle it drives the array write port: one buffered byte per cycle for a page write, or one address per cycle for a whole-array fill with 0x00 or 0xFF. The busy flag stays high for a fixed number of system-clock cycles. Both durations are parameters, so the millisecond-scale cycle can be shortened for simulation. `PAGE_TICKS` must be at least 16 and `ARRAY_TICKS` at least 256.

Top module: `wpc_ctrl`

## Requirements
- R1: After reset `status_o` reads 0x04. The bit layout is: bit0 busy, bit1 write-enable latch, bit2 protect code low bit, bit3 protect code high bit. Bits 7..4 are always 0. The reset protect code is 01.
- R2: A strobe (`cmd_vld_i`=1) with `cmd_i`=1 sets the write-enable latch, and `cmd_i`=2 clears it. Both codes act in any state, including during a write cycle.
- R3: A page write starts with `cmd_i`=3, and `addr_i` gives the start address. Received byte n goes to address {addr_i[7:4], (addr_i[3:0]+n) mod 16}. A later byte that lands on the same slot replaces the earlier one. Each buffered slot is written to the array exactly once.
- R4: Protect code 00 locks nothing, 01 locks 0xC0–0xFF, 10 locks 0x80–0xFF and 11 locks everything. A page write aimed at a locked page starts no cycle and writes nothing, and the write-enable latch keeps its value.
- R5: If the write-enable latch is 0 at termination, no page, status or fill write runs. The busy flag stays 0.
- R6: A termination with no data byte received, or an `abort_i` before termination, discards the pending write. No cycle starts and the latch is unchanged.
- R7: Every accepted page, status, clear or set write clears the write-enable latch in the same cycle that busy rises.
- R8: Busy is high for exactly `PAGE_TICKS` cycles for page and status writes, and `ARRAY_TICKS` cycles for fills. The array write enable is asserted only while busy is high.
- R9: A status write starts with `cmd_i`=4. Bits 3..2 of the last data byte become the protect code as busy rises, so a read during the cycle already shows the new code.
- R10: Command `cmd_i`=5 writes 0x00 and `cmd_i`=6 writes 0xFF to every address. Either one runs only when the latch is 1 and the protect code is 00; otherwise it is ignored and the latch is kept.
- R11: Commands 3 to 6, data bytes and terminations that arrive while busy have no effect.
- R12: Busy rises only in the cycle after `term_i` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code (1 latch set, 2 latch clear, 3 page, 4 status, 5 clear all, 6 set all) |
| addr_i | input | 8 | Start address, sampled with a page-write strobe |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | 8 | Data byte |
| term_i | input | 1 | Normal termination of the current command |
| abort_i | input | 1 | Abort of the current command |
| status_o | output | 8 | Status byte |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | 8 | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
A stale protect code or write-enable latch shows up on `status_o` one cycle after the command that should have changed it. It also shows up as array writes that land in, or miss, a locked page during the next cycle. A wrong page-buffer pointer puts bytes at the wrong addresses or leaves slots unwritten; this is visible at the array port within 16 cycles of the cycle start. A timer fault shows as a busy pulse of the wrong length.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    // Command codes presented by the sequencer on cmd_i
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_LATCH_ON = 3'd1,
        OP_LATCH_OFF= 3'd2,
        OP_PAGE     = 3'd3,
        OP_STATUS   = 3'd4,
        OP_CLR_ALL  = 3'd5,
        OP_SET_ALL  = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LOAD_PAGE = 3'd1,
        ST_LOAD_STAT = 3'd2,
        ST_ARM_FILL  = 3'd3,
        ST_RUN_PAGE  = 3'd4,
        ST_RUN_STAT  = 3'd5,
        ST_RUN_FILL  = 3'd6
    } state_e;

    localparam int STATUS_W = 8;
    localparam int PROT_W   = 2;

endpackage

// File: rtl/wpc_prot_decode.sv
module wpc_prot_decode #(
    parameter int PN_W = 4
) (
    input  logic [1:0]      code_i,
    input  logic [PN_W-1:0] page_i,
    output logic            locked_o
);
    // page numbers at or above these thresholds fall inside the locked region
    localparam logic [PN_W-1:0] QTR_BASE  = PN_W'(3) << (PN_W - 2);
    localparam logic [PN_W-1:0] HALF_BASE = PN_W'(1) << (PN_W - 1);

    always_comb begin
        case (code_i)
            2'b00:   locked_o = 1'b0;
            2'b01:   locked_o = (page_i >= QTR_BASE);
            2'b10:   locked_o = (page_i >= HALF_BASE);
            default: locked_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wpc_page_buf.sv
module wpc_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic [PAGE_W-1:0] start_lo_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [PAGE_W-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_vld_o,
    output logic              any_o
);
    localparam int SLOTS = 1 << PAGE_W;

    typedef struct packed {
        logic [SLOTS-1:0]  vld;
        logic [PAGE_W-1:0] ptr;
    } bctl_t;

    bctl_t ctl_d, ctl_q;
    logic [SLOTS*DATA_W-1:0] flat;

    always_comb begin
        ctl_d = ctl_q;
        if (open_i) begin
            ctl_d.vld = '0;
            ctl_d.ptr = start_lo_i;
        end else if (push_i) begin
            ctl_d.vld[ctl_q.ptr] = 1'b1;
            ctl_d.ptr            = ctl_q.ptr + 1'b1;  // wraps inside the page
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= '0;
            else if (push_i && !open_i && ctl_q.ptr == PAGE_W'(g))
                slot_q <= data_i;
        end
        assign flat[g*DATA_W +: DATA_W] = slot_q;
    end

    assign rd_data_o = flat[32'(rd_idx_i)*DATA_W +: DATA_W];
    assign rd_vld_o  = ctl_q.vld[rd_idx_i];
    assign any_o     = |ctl_q.vld;

endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
    parameter int TICK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TICK_W-1:0] len_i,
    output logic [TICK_W-1:0] cnt_o,
    output logic              last_o
);
    typedef struct packed {
        logic              run;
        logic [TICK_W-1:0] cnt;
        logic [TICK_W-1:0] len;
    } tctl_t;

    tctl_t t_d, t_q;
    logic  at_end;

    assign at_end = (t_q.cnt == (t_q.len - 1'b1));

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.run = 1'b1;
            t_d.cnt = '0;
            t_d.len = len_i;
        end else if (t_q.run) begin
            if (at_end) t_d.run = 1'b0;
            else        t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign cnt_o  = t_q.cnt;
    assign last_o = t_q.run && at_end;

endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int PAGE_TICKS  = 40,
    parameter int ARRAY_TICKS = 300
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_vld_i,
    input  logic [2:0]          cmd_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                byte_vld_i,
    input  logic [DATA_W-1:0]   byte_i,
    input  logic                term_i,
    input  logic                abort_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                arr_we_o,
    output logic [ADDR_W-1:0]   arr_addr_o,
    output logic [DATA_W-1:0]   arr_wdata_o
);
    localparam int SLOTS  = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PN_W   = ADDR_W - PAGE_W;
    localparam int MAX_T  = (PAGE_TICKS > ARRAY_TICKS) ? PAGE_TICKS : ARRAY_TICKS;
    localparam int TICK_W = $clog2(MAX_T + 1);

    typedef struct packed {
        state_e            st;
        logic              wel;
        logic [PROT_W-1:0] bp;
        logic [PROT_W-1:0] bp_new;
        logic              stat_got;
        logic [PN_W-1:0]   page;
        logic [DATA_W-1:0] fill;
    } ctl_t;

    ctl_t c_d, c_q;
    op_e  op;

    logic              buf_open, buf_push, buf_rd_vld, buf_any;
    logic [DATA_W-1:0] buf_rd_data;
    logic              tmr_start, tmr_last;
    logic [TICK_W-1:0] tmr_len, tmr_cnt;
    logic              page_locked;
    logic              busy;

    // ---------------- sub-blocks ----------------
    wpc_prot_decode #(.PN_W(PN_W)) u_prot (
        .code_i   (c_q.bp),
        .page_i   (c_q.page),
        .locked_o (page_locked)
    );

    wpc_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (buf_open),
        .start_lo_i (addr_i[PAGE_W-1:0]),
        .push_i     (buf_push),
        .data_i     (byte_i),
        .rd_idx_i   (tmr_cnt[PAGE_W-1:0]),
        .rd_data_o  (buf_rd_data),
        .rd_vld_o   (buf_rd_vld),
        .any_o      (buf_any)
    );

    wpc_cycle_timer #(.TICK_W(TICK_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .len_i   (tmr_len),
        .cnt_o   (tmr_cnt),
        .last_o  (tmr_last)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        c_d       = c_q;
        op        = op_e'(cmd_i);
        buf_open  = 1'b0;
        buf_push  = 1'b0;
        tmr_start = 1'b0;
        tmr_len   = '0;

        // latch set/clear strobes act in every state
        if (cmd_vld_i) begin
            if (op == OP_LATCH_ON)       c_d.wel = 1'b1;
            else if (op == OP_LATCH_OFF) c_d.wel = 1'b0;
        end

        case (c_q.st)
            ST_IDLE: begin
                if (cmd_vld_i) begin
                    case (op)
                        OP_PAGE: begin
                            c_d.st   = ST_LOAD_PAGE;
                            c_d.page = addr_i[ADDR_W-1:PAGE_W];
                            buf_open = 1'b1;
                        end
                        OP_STATUS: begin
                            c_d.st       = ST_LOAD_STAT;
                            c_d.stat_got = 1'b0;
                        end
                        OP_CLR_ALL: begin
                            c_d.st   = ST_ARM_FILL;
                            c_d.fill = '0;
                        end
                        OP_SET_ALL: begin
                            c_d.st   = ST_ARM_FILL;
                            c_d.fill = '1;
                        end
                        default: ;
                    endcase
                end
            end

            ST_LOAD_PAGE: begin
                if (abort_i) begin
                    c_d.st = ST_IDLE;
                end else if (term_i) begin
                    if (buf_any && c_q.wel && !page_locked) begin
                        c_d.st    = ST_RUN_PAGE;
                        c_d.wel   = 1'b0;
                        tmr_start = 1'b1;
                        tmr_len   = TICK_W'(PAGE_TICKS);
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                end else if (byte_vld_i) begin
                    buf_push = 1'b1;
                end
            end

            ST_LOAD_STAT: begin
                if (abort_i) begin
                    c_d.st = ST_IDLE;
                end else if (term_i) begin
                    if (c_q.stat_got && c_q.wel) begin
                        c_d.st    = ST_RUN_STAT;
                        c_d.bp    = c_q.bp_new;
                        c_d.wel   = 1'b0;
                        tmr_start = 1'b1;
                        tmr_len   = TICK_W'(PAGE_TICKS);
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                end else if (byte_vld_i) begin
                    c_d.bp_new   = byte_i[3:2];
                    c_d.stat_got = 1'b1;
                end
            end

            ST_ARM_FILL: begin
                if (abort_i) begin
                    c_d.st = ST_IDLE;
                end else if (term_i) begin
                    if (c_q.wel && c_q.bp == 2'b00) begin
                        c_d.st    = ST_RUN_FILL;
                        c_d.wel   = 1'b0;
                        tmr_start = 1'b1;
                        tmr_len   = TICK_W'(ARRAY_TICKS);
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                end
            end

            ST_RUN_PAGE, ST_RUN_STAT, ST_RUN_FILL: begin
                if (tmr_last) c_d.st = ST_IDLE;
            end

            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q          <= '0;
            c_q.st       <= ST_IDLE;
            c_q.bp       <= 2'b01;
        end else begin
            c_q <= c_d;
        end
    end

    // ---------------- outputs ----------------
    assign busy = (c_q.st == ST_RUN_PAGE) || (c_q.st == ST_RUN_STAT) ||
                  (c_q.st == ST_RUN_FILL);

    assign status_o = {4'b0000, c_q.bp, c_q.wel, busy};

    always_comb begin
        arr_we_o    = 1'b0;
        arr_addr_o  = '0;
        arr_wdata_o = '0;
        if (c_q.st == ST_RUN_PAGE) begin
            arr_we_o    = (tmr_cnt < TICK_W'(SLOTS)) && buf_rd_vld;
            arr_addr_o  = {c_q.page, tmr_cnt[PAGE_W-1:0]};
            arr_wdata_o = buf_rd_data;
        end else if (c_q.st == ST_RUN_FILL) begin
            arr_we_o    = (tmr_cnt < TICK_W'(DEPTH));
            arr_addr_o  = tmr_cnt[ADDR_W-1:0];
            arr_wdata_o = c_q.fill;
        end
    end

endmodule

// File: rtl/wpc_ctrl_chk.sv
module wpc_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_vld_i,
    input logic [2:0]        cmd_i,
    input logic              term_i,
    input logic [3:0]        stat_i,
    input logic              arr_we_o,
    input logic [ADDR_W-1:0] arr_addr_o
);
    localparam logic [ADDR_W-1:0] QTR_ADDR  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_ADDR = ADDR_W'(1) << (ADDR_W - 1);

    logic addr_locked;
    always_comb begin
        case (stat_i[3:2])
            2'b00:   addr_locked = 1'b0;
            2'b01:   addr_locked = (arr_addr_o >= QTR_ADDR);
            2'b10:   addr_locked = (arr_addr_o >= HALF_ADDR);
            default: addr_locked = 1'b1;
        endcase
    end

    // R8: array writes only inside a busy window
    a_r8_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> stat_i[0]);

    // R4: never write into a locked region
    a_r4_we_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> !addr_locked);

    // R7: latch is already clear when busy rises
    a_r7_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_i[0]) |-> !stat_i[1]);

    // R12: busy rises only after a termination
    a_r12_wip_after_term: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_i[0]) |-> $past(term_i));

    // R2: latch goes high only after a latch-set strobe
    a_r2_wel_set_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_i[1]) |-> $past(cmd_vld_i && cmd_i == 3'd1));

    // R9: protect code changes only as a status write begins
    a_r9_bp_with_wip: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_i[3:2]) |-> $rose(stat_i[0]));

endmodule

bind wpc_ctrl wpc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_vld_i  (cmd_vld_i),
    .cmd_i      (cmd_i),
    .term_i     (term_i),
    .stat_i     (status_o[3:0]),
    .arr_we_o   (arr_we_o),
    .arr_addr_o (arr_addr_o)
);

// File: tb/wpc_ctrl_tb.sv
module wpc_ctrl_tb;
    localparam int CLK_P   = 10;
    localparam int T_PAGE  = 40;
    localparam int T_FILL  = 300;
    localparam int NVEC    = 9;

    // {bp[1:0], addr[7:0], nbytes[4:0], seed[7:0], latch_on[0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {2'b00, 8'h10, 5'd3,  8'h21, 1'b1},
        {2'b00, 8'h3D, 5'd5,  8'h40, 1'b1},
        {2'b00, 8'h52, 5'd18, 8'h60, 1'b1},
        {2'b01, 8'hC4, 5'd2,  8'h80, 1'b1},
        {2'b01, 8'hB0, 5'd2,  8'h90, 1'b1},
        {2'b10, 8'h84, 5'd2,  8'hA0, 1'b1},
        {2'b11, 8'h04, 5'd1,  8'hB0, 1'b1},
        {2'b00, 8'h20, 5'd4,  8'hC0, 1'b0},
        {2'b00, 8'h70, 5'd0,  8'hD0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_vld_i, byte_vld_i, term_i, abort_i;
    logic [2:0] cmd_i;
    logic [7:0] addr_i, byte_i;
    logic [7:0] status_o;
    logic       arr_we_o;
    logic [7:0] arr_addr_o, arr_wdata_o;

    logic [7:0] act_mem [256];
    logic [7:0] exp_mem [256];
    int n_chk = 0, n_fail = 0, wip_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    wpc_ctrl #(.PAGE_TICKS(T_PAGE), .ARRAY_TICKS(T_FILL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i),
        .addr_i(addr_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .term_i(term_i), .abort_i(abort_i), .status_o(status_o),
        .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o)
    );

    // array model and busy-width monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (arr_we_o) act_mem[arr_addr_o] = arr_wdata_o;
        if (status_o[0]) wip_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_mem(input string tag);
        int bad = 0;
        for (int a = 0; a < 256; a++) if (act_mem[a] !== exp_mem[a]) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic send_cmd(input logic [2:0] c, input logic [7:0] a);
        @(negedge clk); cmd_vld_i = 1'b1; cmd_i = c; addr_i = a;
        @(negedge clk); cmd_vld_i = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
        @(negedge clk); byte_vld_i = 1'b0;
    endtask

    task automatic send_term();
        @(negedge clk); term_i = 1'b1;
        @(negedge clk); term_i = 1'b0;
    endtask

    task automatic send_abort();
        @(negedge clk); abort_i = 1'b1;
        @(negedge clk); abort_i = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (status_o[0] && g < 2000) begin @(negedge clk); g++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic set_prot(input logic [1:0] code);
        send_cmd(3'd1, 8'h00);
        send_cmd(3'd4, 8'h00);
        send_byte({4'h0, code, 2'b00});
        send_term();
        wait_idle();
    endtask

    function automatic bit locked_at(input logic [1:0] code, input logic [7:0] a);
        case (code)
            2'b00:   return 1'b0;
            2'b01:   return a >= 8'hC0;
            2'b10:   return a >= 8'h80;
            default: return 1'b1;
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin act_mem[a] = 8'h00; exp_mem[a] = 8'h00; end
        rst_n = 1'b0; cmd_vld_i = 0; cmd_i = 0; addr_i = 0;
        byte_vld_i = 0; byte_i = 0; term_i = 0; abort_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(status_o == 8'h04, "R1 reset status", status_o, 8'h04);
        // R2 latch set / clear
        send_cmd(3'd1, 8'h00);
        chk(status_o == 8'h06, "R2 latch set", status_o, 8'h06);
        send_cmd(3'd2, 8'h00);
        chk(status_o == 8'h04, "R2 latch clear", status_o, 8'h04);

        // table walk: page writes against protection codes (R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] v = VEC[i];
            logic [1:0]  code = v[23:22];
            logic [7:0]  sa = v[21:14];
            int          nb = int'(v[13:9]);
            logic [7:0]  seed = v[8:1];
            logic        won = v[0];
            bit          go;
            set_prot(code);
            if (won) send_cmd(3'd1, 8'h00);
            send_cmd(3'd3, sa);
            for (int k = 0; k < nb; k++) send_byte(seed + 8'(k));
            go = won && (nb > 0) && !locked_at(code, sa);
            wip_cnt = 0;
            send_term();
            wait_idle();
            if (go)
                for (int k = 0; k < nb; k++)
                    exp_mem[{sa[7:4], 4'(sa[3:0] + 4'(k))}] = seed + 8'(k);
            chk_mem($sformatf("R3 R4 R5 R6 page vec %0d", i));
            chk(wip_cnt == (go ? T_PAGE : 0), $sformatf("R8 busy width vec %0d", i),
                wip_cnt, go ? T_PAGE : 0);
            chk(status_o[1] == (go ? 1'b0 : won), $sformatf("R7 latch after vec %0d", i),
                status_o[1], go ? 0 : won);
        end

        // R9 new protect code visible while busy
        send_cmd(3'd1, 8'h00);
        send_cmd(3'd4, 8'h00);
        send_byte(8'hF8);  // bits 3..2 = 10
        send_term();
        chk(status_o == 8'h09, "R9 status during write", status_o, 8'h09);
        wait_idle();
        chk(status_o == 8'h08, "R9 status after write", status_o, 8'h08);

        // R10 set-all refused under protection, latch kept
        send_cmd(3'd1, 8'h00);
        send_cmd(3'd6, 8'h00);
        wip_cnt = 0;
        send_term();
        repeat (5) @(negedge clk);
        chk(wip_cnt == 0, "R10 refused fill busy", wip_cnt, 0);
        chk(status_o == 8'h0A, "R10 refused fill latch", status_o, 8'h0A);
        chk_mem("R10 refused fill array");

        // R10 set-all accepted
        set_prot(2'b00);
        send_cmd(3'd1, 8'h00);
        send_cmd(3'd6, 8'h00);
        wip_cnt = 0;
        send_term();
        wait_idle();
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'hFF;
        chk_mem("R10 set all array");
        chk(wip_cnt == T_FILL, "R8 fill busy width", wip_cnt, T_FILL);
        chk(status_o == 8'h00, "R7 latch after fill", status_o, 8'h00);

        // R11 commands ignored while busy; R2 latch set during busy
        send_cmd(3'd1, 8'h00);
        send_cmd(3'd3, 8'h00);
        send_byte(8'h5A);
        wip_cnt = 0;
        send_term();
        send_cmd(3'd1, 8'h00);
        chk(status_o == 8'h03, "R2 latch set while busy", status_o, 8'h03);
        send_cmd(3'd3, 8'h40);
        send_byte(8'h77);
        send_term();
        wait_idle();
        exp_mem[8'h00] = 8'h5A;
        chk_mem("R11 busy commands ignored");
        chk(wip_cnt == T_PAGE, "R11 single busy window", wip_cnt, T_PAGE);
        chk(status_o == 8'h02, "R11 status after", status_o, 8'h02);

        // R6 abort discards the write
        send_cmd(3'd3, 8'h90);
        send_byte(8'h33);
        send_abort();
        wip_cnt = 0;
        send_term();
        repeat (5) @(negedge clk);
        chk(wip_cnt == 0, "R6 abort no busy", wip_cnt, 0);
        chk(status_o == 8'h02, "R6 abort latch kept", status_o, 8'h02);
        chk_mem("R6 abort array");

        // R10 clear-all
        send_cmd(3'd5, 8'h00);
        wip_cnt = 0;
        send_term();
        wait_idle();
        for (int a = 0; a < 256; a++) exp_mem[a] = 8'h00;
        chk_mem("R10 clear all array");
        chk(wip_cnt == T_FILL, "R8 clear busy width", wip_cnt, T_FILL);

        summary();
        $finish;
    end

endmodule